// File: doc/BRIEF.md
# Human Consent Gate for Signing and Decryption Requests

This block stands between a host command port and a key-handling engine. Each host request carries an operation code. Requests that cannot misuse a private key are forwarded at once. A signing or decryption request is held, and a "waiting for consent" lamp lights. The request goes ahead only after an operator presses a physical approve button. A reject button, or the expiry of a tick-counted window, turns the request into a denial. The denial returns to the host with the same status an access-list refusal would give.

Only one request is outstanding at a time. While a request waits, the host port is held off. The two buttons enter through synchronisers and a debouncer. Only a fresh press made while the request waits counts. A button already held down when the request arrives does nothing until it is let go and pressed again. The time window is a run-time value in timer ticks. The value zero selects a built-in default equal to thirty seconds of ticks.

Top module: `consent_gate`

## Requirements
- R1: Out of reset `req_ready` is 1, both lamps are off and `dec_valid` is 0.
- R2: An accepted request whose `req_op` is neither 1 (sign) nor 2 (decrypt) produces `dec_valid`=1 with `dec_fwd`=1 and the same op in the next cycle, with no button involved.
- R3: An accepted request with `req_op` 1 or 2 is held: `led_wait` is 1 and `req_ready` is 0 until a decision is issued.
- R4: A debounced press of the approve button while a request is held issues `dec_fwd`=1 with the held op and returns to idle.
- R5: A debounced press of the reject button while a request is held issues `dec_fwd`=0 (deny) with the held op.
- R6: If no press arrives, the request is denied on the tick that brings the count of `tick` pulses seen while held to `timeout_ticks`. A value of 0 means the default of 30 x TICKS_PER_SEC ticks. Ticks in idle are not counted.
- R7: Approve and reject presses seen in the same cycle give a deny.
- R8: A button level that does not stay stable for DEB_CYC clock cycles is not taken as a press.
- R9: A button already held when a request is accepted has no effect until it is released and pressed again.
- R10: `led_denied` turns on with every deny and stays on until the next request is accepted.
- R11: Every accepted request yields exactly one single-cycle `dec_valid`, in order of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_op | input | OP_W | Host operation code (1 sign, 2 decrypt) |
| req_ready | output | 1 | Gate can accept a request |
| tick | input | 1 | One-cycle timer tick pulse |
| timeout_ticks | input | TMO_W | Consent window in ticks, 0 = default |
| btn_approve | input | 1 | Raw approve pushbutton, high when pressed |
| btn_reject | input | 1 | Raw reject pushbutton, high when pressed |
| led_wait | output | 1 | Consent-needed lamp |
| led_denied | output | 1 | Denied lamp |
| dec_valid | output | 1 | Decision pulse toward the target |
| dec_fwd | output | 1 | 1 forward, 0 deny |
| dec_op | output | OP_W | Operation the decision refers to |

## Verification
The approve press and the reject press can reach the decision logic in the same cycle. The bench raises both raw buttons on the same clock, so both pass through identical synchroniser and debounce paths together. The scoreboard then requires a deny for that request. A second case is an approve press arriving just after the last timeout tick. The bench expects the timeout to have decided first, and the late press must leave the next request unaffected.

// File: rtl/consent_pkg.sv
package consent_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_SIGN    = 3'd1;
    localparam logic [OP_W-1:0] OP_DECRYPT = 3'd2;

    typedef enum logic [0:0] {
        GS_IDLE = 1'b0,
        GS_HELD = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic            fwd;
        logic [OP_W-1:0] op;
    } decision_t;

    function automatic logic needs_consent(input logic [OP_W-1:0] op);
        return (op == OP_SIGN) || (op == OP_DECRYPT);
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level,
    output logic press
);
    localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
    localparam logic [CW-1:0] CMAX = CW'(DEB_CYC - 1);

    logic          sync_a, sync_b;
    logic [CW-1:0] stab_cnt;
    logic          lvl_q, lvl_d1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= 1'b0;
            sync_b   <= 1'b0;
            stab_cnt <= '0;
            lvl_q    <= 1'b0;
            lvl_d1   <= 1'b0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
            lvl_d1 <= lvl_q;
            if (sync_b == lvl_q) begin
                stab_cnt <= '0;
            end else if (stab_cnt == CMAX) begin
                stab_cnt <= '0;
                lvl_q    <= sync_b;
            end else begin
                stab_cnt <= stab_cnt + 1'b1;
            end
        end
    end

    assign level = lvl_q;
    assign press = lvl_q & ~lvl_d1;

    // R8
    level_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != lvl_d1) |-> $past(sync_b != lvl_d1));

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int TMO_W       = 16,
    parameter int DEFAULT_TMO = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit_in,
    output logic             expired
);
    localparam logic [TMO_W-1:0] DEF_LIM = TMO_W'(DEFAULT_TMO);

    logic [TMO_W-1:0] cnt;
    logic [TMO_W-1:0] lim_q;

    assign expired = run && tick && ({1'b0, cnt} + 1'b1 >= {1'b0, lim_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            lim_q <= DEF_LIM;
        end else if (start) begin
            cnt   <= '0;
            lim_q <= (limit_in == '0) ? DEF_LIM : limit_in;
        end else if (run && tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    count_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < lim_q));

endmodule

// File: rtl/consent_fsm.sv
module consent_fsm
    import consent_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [OP_W-1:0] req_op,
    input  logic            ok_press,
    input  logic            no_press,
    input  logic            expired,
    output logic            req_ready,
    output logic            tmr_start,
    output logic            held,
    output logic            led_denied,
    output decision_t       dec,
    output logic            dec_valid
);
    gate_state_e     state;
    logic [OP_W-1:0] held_op;
    logic            accept;
    logic            deny_now;
    logic            fwd_now;

    assign req_ready = (state == GS_IDLE);
    assign held      = (state == GS_HELD);
    assign accept    = req_valid && req_ready;
    assign tmr_start = accept && needs_consent(req_op);
    assign deny_now  = held && (no_press || expired);
    assign fwd_now   = held && ok_press && !deny_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= GS_IDLE;
            held_op    <= '0;
            led_denied <= 1'b0;
            dec        <= '0;
            dec_valid  <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (accept) begin
                led_denied <= 1'b0;
                if (needs_consent(req_op)) begin
                    state   <= GS_HELD;
                    held_op <= req_op;
                end else begin
                    dec_valid <= 1'b1;
                    dec.fwd   <= 1'b1;
                    dec.op    <= req_op;
                end
            end else if (deny_now) begin
                state      <= GS_IDLE;
                led_denied <= 1'b1;
                dec_valid  <= 1'b1;
                dec.fwd    <= 1'b0;
                dec.op     <= held_op;
            end else if (fwd_now) begin
                state     <= GS_IDLE;
                dec_valid <= 1'b1;
                dec.fwd   <= 1'b1;
                dec.op    <= held_op;
            end
        end
    end

    // R5
    reject_denies_chk: assert property (@(posedge clk) disable iff (rst)
        (held && no_press) |=> (dec_valid && !dec.fwd && led_denied));

    // R4
    approve_forwards_chk: assert property (@(posedge clk) disable iff (rst)
        (held && ok_press && !no_press && !expired) |=> (dec_valid && dec.fwd));

endmodule

// File: rtl/consent_gate.sv
module consent_gate
    import consent_pkg::*;
#(
    parameter int DEB_CYC       = 16,
    parameter int TMO_W         = 16,
    parameter int TICKS_PER_SEC = 10,
    parameter int DEFAULT_SECS  = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [OP_W-1:0]  req_op,
    output logic             req_ready,
    input  logic             tick,
    input  logic [TMO_W-1:0] timeout_ticks,
    input  logic             btn_approve,
    input  logic             btn_reject,
    output logic             led_wait,
    output logic             led_denied,
    output logic             dec_valid,
    output logic             dec_fwd,
    output logic [OP_W-1:0]  dec_op
);
    localparam int DEFAULT_TMO = TICKS_PER_SEC * DEFAULT_SECS;
    localparam int NBTN = 2;

    logic [NBTN-1:0] raw_btn, btn_level, btn_press;
    logic            tmr_start, held, expired;
    decision_t       dec;

    assign raw_btn = {btn_reject, btn_approve};

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        btn_conditioner #(.DEB_CYC(DEB_CYC)) u_btn (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_btn[b]),
            .level (btn_level[b]),
            .press (btn_press[b])
        );
    end

    tick_timer #(.TMO_W(TMO_W), .DEFAULT_TMO(DEFAULT_TMO)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (tmr_start),
        .run      (held),
        .tick     (tick),
        .limit_in (timeout_ticks),
        .expired  (expired)
    );

    consent_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .ok_press   (btn_press[0]),
        .no_press   (btn_press[1]),
        .expired    (expired),
        .req_ready  (req_ready),
        .tmr_start  (tmr_start),
        .held       (held),
        .led_denied (led_denied),
        .dec        (dec),
        .dec_valid  (dec_valid)
    );

    assign led_wait = held;
    assign dec_fwd  = dec.fwd;
    assign dec_op   = dec.op;

    // R2
    passthrough_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !needs_consent(req_op)) |=> (dec_valid && dec_fwd));

    // R3
    sensitive_held_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && needs_consent(req_op)) |=> (led_wait && !req_ready && !dec_valid));

    // R7
    both_buttons_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (led_wait && btn_press[0] && btn_press[1]) |=> (dec_valid && !dec_fwd));

    // R11
    decision_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> ($past(req_valid && req_ready) || $past(led_wait)));

    // R9
    held_level_no_press_chk: assert property (@(posedge clk) disable iff (rst)
        $past(btn_level[0]) |-> !btn_press[0]);

    // R6
    expiry_only_when_held_chk: assert property (@(posedge clk) disable iff (rst)
        expired |-> (led_wait && tick));

endmodule

// File: tb/sim_consent_gate.sv
module sim_consent_gate;
    import consent_pkg::*;

    localparam int DEB = 4;
    localparam int TW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [OP_W-1:0] req_op = '0;
    logic            req_ready;
    logic            tick = 1'b0;
    logic [TW-1:0]   timeout_ticks = 16'd5;
    logic            btn_approve = 1'b0;
    logic            btn_reject = 1'b0;
    logic            led_wait, led_denied, dec_valid, dec_fwd;
    logic [OP_W-1:0] dec_op;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    decision_t exp_q[$];
    string     tag_q[$];

    always #2.5 clk = ~clk;

    consent_gate #(.DEB_CYC(DEB), .TMO_W(TW), .TICKS_PER_SEC(10), .DEFAULT_SECS(30)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
        .tick(tick), .timeout_ticks(timeout_ticks), .btn_approve(btn_approve),
        .btn_reject(btn_reject), .led_wait(led_wait), .led_denied(led_denied),
        .dec_valid(dec_valid), .dec_fwd(dec_fwd), .dec_op(dec_op)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops expected decisions
    always @(negedge clk) begin
        cyc++;
        if (!rst && dec_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected decision", int'(dec_op), -1);
            end else begin
                decision_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(dec_fwd == e.fwd && dec_op == e.op, t,
                      int'({dec_fwd, dec_op}), int'({e.fwd, e.op}));
            end
        end
        if (cyc > 100000) begin
            check(1'b0, "watchdog", cyc, 100000);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [OP_W-1:0] op, input bit fwd, input string tag);
        decision_t d;
        d.fwd = fwd;
        d.op  = op;
        exp_q.push_back(d);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_op    = op;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic press(input bit ok, input bit no, input int hold);
        btn_approve = ok;
        btn_reject  = no;
        idle(hold);
        btn_approve = 1'b0;
        btn_reject  = 1'b0;
        idle(12);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        idle(1);
        tick = 1'b0;
        idle(2);
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) idle(1);
        check(exp_q.size() == 0, "R11 decision missing", exp_q.size(), 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        #1;
        // R1
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(led_wait == 1'b0 && led_denied == 1'b0, "R1 leds", {led_wait, led_denied}, 0);
        check(dec_valid == 1'b0, "R1 dec_valid", dec_valid, 0);

        // R2: pass-through ops, including ticks in idle
        pulse_tick();
        send(3'd0, 1'b1, "R2 op0");
        send(3'd5, 1'b1, "R2 op5");
        send(3'd7, 1'b1, "R2 op7");
        drain();
        check(led_wait == 1'b0, "R2 no wait lamp", led_wait, 0);

        // R3 + R4: sign then approve
        send(OP_SIGN, 1'b1, "R4 approve sign");
        idle(2);
        check(led_wait == 1'b1, "R3 wait lamp", led_wait, 1);
        check(req_ready == 1'b0, "R3 ready low", req_ready, 0);
        press(1'b1, 1'b0, 10);
        drain();
        check(led_wait == 1'b0 && req_ready == 1'b1, "R4 back to idle", {led_wait, req_ready}, 1);

        // R5 + R10: decrypt then reject
        send(OP_DECRYPT, 1'b0, "R5 reject decrypt");
        press(1'b0, 1'b1, 10);
        drain();
        check(led_denied == 1'b1, "R10 denied lamp on", led_denied, 1);
        idle(5);
        check(led_denied == 1'b1, "R10 denied lamp holds", led_denied, 1);
        send(3'd4, 1'b1, "R10 next request");
        drain();
        check(led_denied == 1'b0, "R10 lamp cleared", led_denied, 0);

        // R8: short glitch ignored
        send(OP_SIGN, 1'b1, "R8 glitch then approve");
        press(1'b1, 1'b0, 2);
        check(led_wait == 1'b1 && dec_valid == 1'b0, "R8 glitch ignored", led_wait, 1);
        press(1'b1, 1'b0, 10);
        drain();

        // R7: both buttons together
        send(OP_SIGN, 1'b0, "R7 both buttons deny");
        press(1'b1, 1'b1, 10);
        drain();

        // R9: approve held before request
        btn_approve = 1'b1;
        idle(12);
        send(OP_DECRYPT, 1'b1, "R9 held press ignored");
        idle(15);
        check(led_wait == 1'b1, "R9 still pending while held", led_wait, 1);
        btn_approve = 1'b0;
        idle(15);
        check(led_wait == 1'b1, "R9 still pending after release", led_wait, 1);
        press(1'b1, 1'b0, 10);
        drain();

        // R6: timeout after exactly 5 ticks
        timeout_ticks = 16'd5;
        send(OP_SIGN, 1'b0, "R6 timeout deny");
        for (int i = 0; i < 4; i++) pulse_tick();
        check(led_wait == 1'b1, "R6 pending before last tick", led_wait, 1);
        pulse_tick();
        drain();
        check(led_denied == 1'b1, "R6 denied lamp", led_denied, 1);
        // late press must not touch the next request
        press(1'b1, 1'b0, 10);
        send(OP_SIGN, 1'b1, "R6 next after late press");
        idle(3);
        check(led_wait == 1'b1, "R6 next request pending", led_wait, 1);
        press(1'b1, 1'b0, 10);
        drain();

        // R6: zero selects default of 300 ticks
        timeout_ticks = '0;
        send(OP_DECRYPT, 1'b0, "R6 default timeout");
        for (int i = 0; i < 299; i++) pulse_tick();
        check(led_wait == 1'b1, "R6 default pending at 299", led_wait, 1);
        pulse_tick();
        drain();

        idle(5);
        finish_run();
    end
endmodule